// File: doc/BRIEF.md
# Random-Access Scan Cell Array

This block holds a bank of state flip-flops that sit between pieces of combinational logic. In normal operation every bit loads its functional input on each system clock. For test, the bits are not linked into a serial shift chain. Instead, each bit can be reached on its own through an address.

A small address register is loaded one bit at a time on its own input, using its own clock. A decoder turns that address into a one-hot select, one line per cell. While test mode is on, a system clock edge writes the shared serial input into the addressed cell only, and every other cell keeps its value. The addressed cell's value is always visible on the shared serial output, so reading a cell needs no clock edge. An address that names no cell selects nothing, and the serial output then reads 0.

The array width is a parameter. The address register is as wide as needed to number every cell.

Top module: `ras_array`

## Requirements
- R1: While `rst_n` is low, every bit of `func_q` is 0 and the address register is 0. After reset, with no address shifted in, `scan_out` shows cell 0.
- R2: With `test_en` low, every cell loads its bit of `func_d` on each rising edge of `clk`, so `func_q` equals the `func_d` value sampled at that edge.
- R3: Each rising edge of `addr_clk` shifts `addr_si` into the least significant bit of the address register and discards its most significant bit. The address is therefore entered most significant bit first, and only the last AWIDTH bits count (AWIDTH = 4 for 12 cells).
- R4: With `test_en` high and an address below NCELLS, a rising `clk` edge loads `scan_in` into cell number `address`, that is, into bit `func_q[address]`.
- R5: With `test_en` high, every cell that is not addressed keeps its value across `clk` edges.
- R6: With an address below NCELLS, `scan_out` equals `func_q[address]` combinationally, with no clock edge needed between loading the address and reading it.
- R7: With an address at or above NCELLS, no cell is selected, `scan_out` is 0, and a test-mode `clk` edge leaves all of `func_q` unchanged.
- R8: Pulses on `addr_clk` never change `func_q`.
- R9: With `test_en` low, the value of the address register has no effect on what the cells load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock for the cells |
| rst_n | input | 1 | Asynchronous active-low reset, released on `clk` |
| test_en | input | 1 | 1 = random-access test mode, 0 = functional mode |
| scan_in | input | 1 | Serial write data shared by all cells |
| scan_out | output | 1 | Value of the addressed cell, 0 when no cell is addressed |
| addr_clk | input | 1 | Shift clock of the address register |
| addr_si | input | 1 | Serial input of the address register, MSB first |
| func_d | input | NCELLS | Functional data into the cells |
| func_q | output | NCELLS | Cell state, back to the functional logic |

## Verification
On every system clock, the assertions check four things. In functional mode the cells follow `func_d`. In test mode only the selected cell changes, and it takes the serial input. The select is never more than one-hot. The serial output follows the addressed cell and drops to zero when the address is out of range.

The bench's scenarios cover the rest. They show that the address shifts in most significant bit first, and that reset leaves cell 0 addressed. They show that a read works without any clock edge and that address shifting never disturbs the cells. A sequence of writes that flip every cell in a scrambled order, followed by a full read-back, shows that every cell can be reached on its own.

// File: rtl/ras_pkg.sv
package ras_pkg;
  function automatic int addr_bits(input int n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/ras_rst_sync.sv
module ras_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;
  logic [1:0] stage_nxt;

  always_comb begin
    stage_nxt = {stage_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= stage_nxt;
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/ras_addr_reg.sv
module ras_addr_reg #(
  parameter int AWIDTH = 4
) (
  input  logic              addr_clk,
  input  logic              rst_n,
  input  logic              addr_si,
  output logic [AWIDTH-1:0] addr
);
  logic [AWIDTH-1:0] addr_nxt;

  generate
    if (AWIDTH == 1) begin : g_one
      always_comb addr_nxt = addr_si;
    end else begin : g_wide
      always_comb addr_nxt = {addr[AWIDTH-2:0], addr_si};
    end
  endgenerate

  always_ff @(posedge addr_clk or negedge rst_n) begin
    if (!rst_n) addr <= '0;
    else        addr <= addr_nxt;
  end
endmodule

// File: rtl/ras_decoder.sv
module ras_decoder #(
  parameter int NCELLS = 12,
  parameter int AWIDTH = 4
) (
  input  logic [AWIDTH-1:0] addr,
  output logic [NCELLS-1:0] sel
);
  for (genvar i = 0; i < NCELLS; i++) begin : g_dec
    localparam logic [AWIDTH-1:0] IDX = AWIDTH'(i);
    assign sel[i] = (addr == IDX);
  end
endmodule

// File: rtl/ras_cell.sv
module ras_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic test_en,
  input  logic sel,
  input  logic scan_in,
  input  logic func_d,
  output logic q
);
  logic q_nxt;

  always_comb begin
    if (!test_en)  q_nxt = func_d;
    else if (sel)  q_nxt = scan_in;
    else           q_nxt = q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= 1'b0;
    else        q <= q_nxt;
  end
endmodule

// File: rtl/ras_array.sv
module ras_array #(
  parameter int NCELLS = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              test_en,
  input  logic              scan_in,
  output logic              scan_out,
  input  logic              addr_clk,
  input  logic              addr_si,
  input  logic [NCELLS-1:0] func_d,
  output logic [NCELLS-1:0] func_q
);
  import ras_pkg::*;
  localparam int AWIDTH = addr_bits(NCELLS);

  logic              rst_sync_n;
  logic [AWIDTH-1:0] addr_q;
  logic [NCELLS-1:0] cell_sel;

  ras_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  ras_addr_reg #(.AWIDTH(AWIDTH)) u_addr (
    .addr_clk (addr_clk),
    .rst_n    (rst_sync_n),
    .addr_si  (addr_si),
    .addr     (addr_q)
  );

  ras_decoder #(.NCELLS(NCELLS), .AWIDTH(AWIDTH)) u_dec (
    .addr (addr_q),
    .sel  (cell_sel)
  );

  for (genvar i = 0; i < NCELLS; i++) begin : g_cell
    ras_cell u_cell (
      .clk     (clk),
      .rst_n   (rst_sync_n),
      .test_en (test_en),
      .sel     (cell_sel[i]),
      .scan_in (scan_in),
      .func_d  (func_d[i]),
      .q       (func_q[i])
    );
  end

  assign scan_out = |(func_q & cell_sel);
endmodule

// File: rtl/ras_array_chk.sv
module ras_array_chk #(
  parameter int NCELLS = 12,
  parameter int AWIDTH = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              test_en,
  input logic              scan_in,
  input logic              scan_out,
  input logic [NCELLS-1:0] func_d,
  input logic [NCELLS-1:0] func_q,
  input logic [AWIDTH-1:0] addr,
  input logic [NCELLS-1:0] sel
);
  localparam logic [AWIDTH:0] NLIM = (AWIDTH+1)'(NCELLS);
  logic in_range;
  assign in_range = ({1'b0, addr} < NLIM);

  // R2
  func_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !test_en |=> func_q == $past(func_d));

  // R4
  sel_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    test_en |=> (func_q & $past(sel)) == ($past(scan_in) ? $past(sel) : '0));

  // R5
  unsel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    test_en |=> (func_q & ~$past(sel)) == ($past(func_q) & ~$past(sel)));

  // R4
  sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel));

  // R6
  read_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_range |-> scan_out == func_q[addr]);

  // R7
  out_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_range |-> (sel == '0 && !scan_out));
endmodule

bind ras_array ras_array_chk #(.NCELLS(NCELLS), .AWIDTH(AWIDTH)) u_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .test_en  (test_en),
  .scan_in  (scan_in),
  .scan_out (scan_out),
  .func_d   (func_d),
  .func_q   (func_q),
  .addr     (addr_q),
  .sel      (cell_sel)
);

// File: tb/ras_array_tb.sv
`timescale 1ns/1ps
module ras_array_tb;
  localparam int  N      = 12;
  localparam int  AW     = 4;
  localparam real PERIOD = 10.0;
  localparam int  NWR    = 12;
  // {address[3:0], bit}; every write flips the cell from the 0x655 base
  localparam logic [4:0] WR_TBL [NWR] = '{
    {4'd7, 1'b1}, {4'd2, 1'b0}, {4'd11, 1'b1}, {4'd0, 1'b0},
    {4'd5, 1'b1}, {4'd9, 1'b0}, {4'd3, 1'b1}, {4'd10, 1'b0},
    {4'd1, 1'b1}, {4'd6, 1'b0}, {4'd8, 1'b1}, {4'd4, 1'b0}
  };

  logic         clk = 1'b0;
  logic         rst_n, test_en, scan_in, addr_clk, addr_si;
  logic [N-1:0] func_d, func_q, model;
  logic         scan_out;
  int           n_chk = 0;
  int           n_bad = 0;

  ras_array #(.NCELLS(N)) u_dut (
    .clk(clk), .rst_n(rst_n), .test_en(test_en), .scan_in(scan_in),
    .scan_out(scan_out), .addr_clk(addr_clk), .addr_si(addr_si),
    .func_d(func_d), .func_q(func_q)
  );

  always #(PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic shift_bit(input logic b);
    addr_si = b;
    #0.2 addr_clk = 1'b1;
    #0.4 addr_clk = 1'b0;
    #0.2;
  endtask

  task automatic load_addr(input logic [AW-1:0] a);
    for (int i = AW-1; i >= 0; i--) shift_bit(a[i]);
  endtask

  initial begin
    #(PERIOD*200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; test_en = 1'b0; scan_in = 1'b0;
    addr_clk = 1'b0; addr_si = 1'b0; func_d = 12'hFFF;
    #(PERIOD*2.5);
    // R1: cells held at 0 during reset
    check("R1", func_q, 12'h000);
    check("R1", scan_out, 1'b0);
    func_d = '0;
    @(negedge clk); rst_n = 1'b1;
    repeat (3) tick();

    // R2: functional load; R1: address reset to 0 so scan_out shows cell 0
    func_d = 12'hA5D; tick();
    check("R2", func_q, 12'hA5D);
    check("R1", scan_out, 1'b1);
    func_d = 12'h3C2; tick();
    check("R2", func_q, 12'h3C2);

    // R9: address does not affect functional mode
    load_addr(4'd5);
    func_d = 12'h655; tick();
    check("R9", func_q, 12'h655);
    model = 12'h655;

    // R4/R5: random-access writes from the table
    test_en = 1'b1;
    for (int k = 0; k < NWR; k++) begin
      load_addr(WR_TBL[k][4:1]);
      scan_in = WR_TBL[k][0];
      model[WR_TBL[k][4:1]] = WR_TBL[k][0];
      tick();
      check("R4_R5", func_q, model);
    end
    check("R4", func_q, 12'h9AA);

    // R6: read back each cell with no clock between address and sample
    for (int i = 0; i < N; i++) begin
      load_addr(AW'(i));
      check("R6", scan_out, model[i]);
      scan_in = model[i];
      tick();
    end

    // R3: shift 1,0,0,1,1 -> oldest bit dropped, address 3 (model[3]=1)
    shift_bit(1'b1); shift_bit(1'b0); shift_bit(1'b0); shift_bit(1'b1); shift_bit(1'b1);
    check("R3", scan_out, 1'b1);
    scan_in = 1'b1; tick();

    // R8: address shifting leaves cells alone
    load_addr(4'd4);
    check("R8", func_q, model);
    scan_in = model[4]; tick();

    // R7: out-of-range addresses
    load_addr(4'd13);
    check("R7", scan_out, 1'b0);
    scan_in = 1'b1; tick();
    check("R7", func_q, model);
    load_addr(4'd12);
    scan_in = 1'b0; tick();
    check("R7", func_q, model);
    check("R7", scan_out, 1'b0);

    // R5: repeated writes to one cell keep others
    load_addr(4'd0);
    scan_in = 1'b1; tick(); tick();
    model[0] = 1'b1;
    check("R5", func_q, model);
    check("R6", scan_out, 1'b1);

    finish_run();
  end
endmodule